// File: doc/BRIEF.md
# Scheduled Link Capture-and-Replay Element

This block sits on one 64-bit link of a time-synchronised crossbar network. A free-running 64-bit local cycle count is its only sense of time. At a programmed count it records the words arriving on the link into a local buffer. At a later programmed count it sends a burst back onto the link. The burst is a three-word header followed by the recorded words. At every other time it drives a fixed idle word, so neighbours can tell an empty slot from data.

Both windows are measured in node slots, and each slot is three 64-bit words long. The buffer holds three words per node. The element runs one capture/replay pass after reset. It arms only while its 96-bit device identifier is marked valid. All of its contents stay readable on a flat output port, so the captured data can be checked after the pass.

Top module: `capture_replay_pe`

## Requirements
- R1: During reset and on the first cycle after it, `link_out` is the idle word 0xAAAA_BBBB_AAAA_BBBB.
- R2: While `id_valid` is low, the element does not arm. The link stays idle and the buffer is unchanged, even when the count passes both start values.
- R3: When armed and the sampled count equals `rd_start`, that cycle's `xbar_in` word and the words of the next 3*`rd_slots`-1 cycles are stored at buffer entries 0, 1, 2 and so on. Entry k appears on `buf_flat[64*k +: 64]` one cycle after its word is sampled.
- R4: With `rd_slots` = 0, nothing is captured and the element goes straight to waiting for the write start.
- R5: `link_out` is the idle word whenever the previous sampled cycle was outside the write window. This includes the cycles before the read window, during it and between the two windows.
- R6: One cycle after the count sampled equals `wr_start`, `link_out` carries `wr_start`. This is word 0 of the burst.
- R7: Burst words 1 and 2 are the device identifier zero-extended to 128 bits, with bits 63:0 first and then bits 127:64.
- R8: Burst word 3+k is buffer entry k, for entries 0 up to 3N-1.
- R9: The burst lasts exactly 3*`wr_slots` cycles. With `wr_slots` = 0 nothing is sent.
- R10: Burst words at position 3+3N and beyond are sent as the idle word.
- R11: After the write window ends, the element stays done until the next reset. When the count passes the start values again, it neither captures nor sends, and the buffer keeps its contents.
- R12: `wr_start` is compared only after the read window has finished. A write start that falls inside the read window produces no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_cnt | input | 64 | Local free-running cycle count |
| xbar_in | input | 64 | Word arriving from the crossbar link |
| id_valid | input | 1 | Device identifier valid; arms the element |
| id_value | input | 96 | Device identifier |
| rd_start | input | 64 | Count at which capture begins |
| rd_slots | input | SLOT_W (3) | Read window length in three-word slots |
| wr_start | input | 64 | Count at which the burst begins |
| wr_slots | input | SLOT_W (3) | Write window length in three-word slots |
| link_out | output | 64 | Registered word sent onto the link |
| buf_flat | output | 3*NODES*64 (768) | Buffer contents, entry k at bits 64*k +: 64 |

## Verification
If the window state machine leaves its waiting state at the wrong count, the header word appears on `link_out` one cycle early or late, or not at all. The data words also shift against the cycle in which each was sampled, so a slip of one cycle shows at the very next edge. A wrong write index shows as a buffer entry landing in the wrong burst position or in the wrong `buf_flat` lane, within one cycle of the word arriving. A state machine that fails to stay in its done state shows later. Buffer entries change, or a second burst appears, when the count revisits the start values.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam logic [63:0] IDLE_WORD = 64'hAAAA_BBBB_AAAA_BBBB;
  localparam int          HDR_WORDS = 3;

  typedef enum logic [2:0] {
    S_WAIT_RD,
    S_READ,
    S_WAIT_WR,
    S_WRITE,
    S_DONE
  } cr_state_e;
endpackage

// File: rtl/cr_window_fsm.sv
module cr_window_fsm
  import cr_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             id_valid,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] rd_start,
  input  logic [LEN_W-1:0] rd_len,
  input  logic [CNT_W-1:0] wr_start,
  input  logic [LEN_W-1:0] wr_len,
  output cr_state_e        st,
  output logic             cap_en,
  output logic [LEN_W-1:0] cap_idx,
  output logic             tx_en,
  output logic [LEN_W-1:0] tx_idx
);
  logic [LEN_W-1:0] idx;
  logic rd_hit, wr_hit;

  assign rd_hit = (st == S_WAIT_RD) && id_valid && (cnt == rd_start);
  assign wr_hit = (st == S_WAIT_WR) && (cnt == wr_start);

  // capture and transmit strobes for the cycle being sampled
  assign cap_en  = (rd_hit && (rd_len != '0)) || (st == S_READ);
  assign cap_idx = (st == S_READ) ? idx : '0;
  assign tx_en   = (wr_hit && (wr_len != '0)) || (st == S_WRITE);
  assign tx_idx  = (st == S_WRITE) ? idx : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_WAIT_RD;
      idx <= '0;
    end else begin
      case (st)
        S_WAIT_RD: if (rd_hit) begin
          if (rd_len > LEN_W'(1)) begin
            st  <= S_READ;
            idx <= LEN_W'(1);
          end else begin
            st <= S_WAIT_WR;
          end
        end
        S_READ: begin
          if (idx == rd_len - LEN_W'(1)) begin
            st  <= S_WAIT_WR;
            idx <= '0;
          end else begin
            idx <= idx + LEN_W'(1);
          end
        end
        S_WAIT_WR: if (wr_hit) begin
          if (wr_len > LEN_W'(1)) begin
            st  <= S_WRITE;
            idx <= LEN_W'(1);
          end else begin
            st <= S_DONE;
          end
        end
        S_WRITE: begin
          if (idx == wr_len - LEN_W'(1)) begin
            st  <= S_DONE;
            idx <= '0;
          end else begin
            idx <= idx + LEN_W'(1);
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/cr_capture_buf.sv
module cr_capture_buf #(
  parameter int W     = 64,
  parameter int DEPTH = 12,
  parameter int LEN_W = 5
) (
  input  logic               clk,
  input  logic               we,
  input  logic [LEN_W-1:0]   waddr,
  input  logic [W-1:0]       wdata,
  input  logic [LEN_W-1:0]   raddr,
  output logic [W-1:0]       rdata,
  output logic [DEPTH*W-1:0] flat
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr < LEN_W'(DEPTH))) mem[waddr[AW-1:0]] <= wdata;
  end

  assign rdata = (raddr < LEN_W'(DEPTH)) ? mem[raddr[AW-1:0]] : '0;

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign flat[g*W +: W] = mem[g];
  end
endmodule

// File: rtl/cr_tx_mux.sv
module cr_tx_mux
  import cr_pkg::*;
#(
  parameter int W     = 64,
  parameter int CNT_W = 64,
  parameter int ID_W  = 96,
  parameter int DEPTH = 12,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic [LEN_W-1:0] tx_idx,
  input  logic [CNT_W-1:0] wr_start,
  input  logic [ID_W-1:0]  id_value,
  input  logic [W-1:0]     rd_word,
  output logic [W-1:0]     link_out
);
  localparam logic [W-1:0] IDLE = W'(IDLE_WORD);

  logic [2*W-1:0] id_ext;
  logic [W-1:0]   nxt;

  assign id_ext = (2*W)'(id_value);

  always_comb begin
    nxt = IDLE;
    if (tx_en) begin
      if (tx_idx == LEN_W'(0))                       nxt = W'(wr_start);
      else if (tx_idx == LEN_W'(1))                  nxt = id_ext[W-1:0];
      else if (tx_idx == LEN_W'(2))                  nxt = id_ext[2*W-1:W];
      else if (tx_idx < LEN_W'(DEPTH + HDR_WORDS))   nxt = rd_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) link_out <= IDLE;
    else     link_out <= nxt;
  end
endmodule

// File: rtl/capture_replay_pe.sv
module capture_replay_pe
  import cr_pkg::*;
#(
  parameter int W      = 64,
  parameter int CNT_W  = 64,
  parameter int ID_W   = 96,
  parameter int NODES  = 4,
  parameter int SLOT_W = $clog2(NODES + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [CNT_W-1:0]       cycle_cnt,
  input  logic [W-1:0]           xbar_in,
  input  logic                   id_valid,
  input  logic [ID_W-1:0]        id_value,
  input  logic [CNT_W-1:0]       rd_start,
  input  logic [SLOT_W-1:0]      rd_slots,
  input  logic [CNT_W-1:0]       wr_start,
  input  logic [SLOT_W-1:0]      wr_slots,
  output logic [W-1:0]           link_out,
  output logic [3*NODES*W-1:0]   buf_flat
);
  localparam int DEPTH = 3 * NODES;
  localparam int LEN_W = SLOT_W + 2;

  cr_state_e        st;
  logic             cap_en, tx_en;
  logic [LEN_W-1:0] cap_idx, tx_idx, rd_len, wr_len, rd_addr;
  logic [W-1:0]     rd_word;

  // slots to cycles: three words per slot
  assign rd_len  = LEN_W'({rd_slots, 1'b0}) + LEN_W'(rd_slots);
  assign wr_len  = LEN_W'({wr_slots, 1'b0}) + LEN_W'(wr_slots);
  assign rd_addr = tx_idx - LEN_W'(HDR_WORDS);

  cr_window_fsm #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst(rst), .id_valid(id_valid), .cnt(cycle_cnt),
    .rd_start(rd_start), .rd_len(rd_len), .wr_start(wr_start), .wr_len(wr_len),
    .st(st), .cap_en(cap_en), .cap_idx(cap_idx), .tx_en(tx_en), .tx_idx(tx_idx)
  );

  cr_capture_buf #(.W(W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_buf (
    .clk(clk), .we(cap_en), .waddr(cap_idx), .wdata(xbar_in),
    .raddr(rd_addr), .rdata(rd_word), .flat(buf_flat)
  );

  cr_tx_mux #(.W(W), .CNT_W(CNT_W), .ID_W(ID_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .tx_idx(tx_idx), .wr_start(wr_start),
    .id_value(id_value), .rd_word(rd_word), .link_out(link_out)
  );
endmodule

// File: rtl/cr_chk.sv
module cr_chk
  import cr_pkg::*;
#(
  parameter int W     = 64,
  parameter int CNT_W = 64,
  parameter int LEN_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             id_valid,
  input logic [CNT_W-1:0] wr_start,
  input logic [W-1:0]     xbar_in,
  input logic [W-1:0]     link_out,
  input logic [W-1:0]     buf0,
  input cr_state_e        st,
  input logic             cap_en,
  input logic [LEN_W-1:0] cap_idx,
  input logic             tx_en,
  input logic [LEN_W-1:0] tx_idx
);
  // R5
  idle_outside_window_chk: assert property (@(posedge clk) disable iff (rst)
    (link_out != W'(IDLE_WORD)) |-> $past(tx_en));

  // R6
  header_stamp_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_en && tx_idx == '0) |=> (link_out == W'($past(wr_start))));

  // R3
  first_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_en && cap_idx == '0) |=> (buf0 == $past(xbar_in)));

  // R2
  no_arm_without_id_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT_RD && !id_valid) |=> (st == S_WAIT_RD));

  // R11
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_DONE) |=> (st == S_DONE && !cap_en && !tx_en));
endmodule

bind capture_replay_pe cr_chk #(.W(W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .id_valid(id_valid), .wr_start(wr_start),
  .xbar_in(xbar_in), .link_out(link_out), .buf0(buf_flat[W-1:0]),
  .st(st), .cap_en(cap_en), .cap_idx(cap_idx), .tx_en(tx_en), .tx_idx(tx_idx)
);

// File: tb/tb_capture_replay_pe.sv
module tb_capture_replay_pe;
  localparam int NODES = 4;
  localparam int DEPTH = 3 * NODES;
  localparam logic [63:0] IDLE = 64'hAAAA_BBBB_AAAA_BBBB;
  // rows: read offset, read slots, write offset from read start, write slots
  localparam int NSC = 5;
  localparam int SC [NSC][4] = '{
    '{1, 4, 12, 4},
    '{3, 2, 11, 4},
    '{2, 0,  2, 1},
    '{1, 4, 13, 7},
    '{5, 1,  6, 0}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1;
  logic [63:0] cycle_cnt = '0, xbar_in = '0, rd_start = '0, wr_start = '0;
  logic id_valid = 1'b0;
  logic [95:0] id_value = '0;
  logic [2:0] rd_slots = '0, wr_slots = '0;
  logic [63:0] link_out;
  logic [DEPTH*64-1:0] buf_flat;

  capture_replay_pe dut (
    .clk(clk), .rst(rst), .cycle_cnt(cycle_cnt), .xbar_in(xbar_in),
    .id_valid(id_valid), .id_value(id_value), .rd_start(rd_start),
    .rd_slots(rd_slots), .wr_start(wr_start), .wr_slots(wr_slots),
    .link_out(link_out), .buf_flat(buf_flat)
  );

  int checks = 0, errors = 0;
  logic [63:0] mb [DEPTH];
  bit          mk [DEPTH];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] dword(input int s, input int i);
    return {16'hD0D0, 16'(s), 32'(i) * 32'h0101_0101 ^ 32'h5A5A_0000};
  endfunction

  task automatic step(input logic [63:0] c, input logic [63:0] d);
    cycle_cnt = c;
    xbar_in   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(64'h0, 64'h0);
    step(64'h1, 64'h0);
    rst = 1'b0;
  endtask

  task automatic check_buf(input string tag);
    for (int i = 0; i < DEPTH; i++)
      if (mk[i]) check(tag, buf_flat[64*i +: 64], mb[i]);
  endtask

  // live: element is expected to arm in this pass
  task automatic run_pass(input int s, input logic [63:0] base, input int rdoff,
                          input int rdsl, input int wroff, input int wrsl,
                          input bit live, input string buf_tag);
    logic [63:0] rs, ws, c, d, wv;
    int rdlen, wrlen, last, w;
    bit wr_ok;
    string itag;
    rdlen = 3 * rdsl;
    wrlen = 3 * wrsl;
    rs = base + 64'(rdoff);
    ws = rs + 64'(wroff);
    rd_start = rs;
    wr_start = ws;
    rd_slots = 3'(rdsl);
    wr_slots = 3'(wrsl);
    wr_ok = (wroff >= rdlen) && (wroff > 0);
    last = rdoff + ((wroff > rdlen) ? wroff : rdlen) + wrlen + 3;
    for (int k = 0; k <= last; k++) begin
      c = base + 64'(k);
      if (c >= rs && c < rs + 64'(rdlen)) d = dword(s, int'(c - rs));
      else d = 64'hFFFF_0000_FFFF_0000 ^ c;
      step(c, d);
      if (live && c >= rs && c < rs + 64'(rdlen) && int'(c - rs) < DEPTH) begin
        mb[int'(c - rs)] = d;
        mk[int'(c - rs)] = 1'b1;
      end
      if (live && wr_ok && c >= ws && c < ws + 64'(wrlen)) begin
        w = int'(c - ws);
        if (w == 0) check("R6 header", link_out, ws);
        else if (w == 1) check("R7 id low", link_out, id_value[63:0]);
        else if (w == 2) check("R7 id high", link_out, {32'h0, id_value[95:64]});
        else if (w - 3 < DEPTH) begin
          if (mk[w - 3]) check("R8 data", link_out, mb[w - 3]);
        end else check("R10 past buffer end", link_out, IDLE);
      end else begin
        if (!id_valid) itag = "R2 idle";
        else if (!live) itag = "R11 idle";
        else if (!wr_ok) itag = "R12 idle";
        else if (c >= ws + 64'(wrlen) || wrlen == 0) itag = "R9 idle";
        else itag = "R5 idle";
        check(itag, link_out, IDLE);
      end
    end
    wv = 64'h0;
    if (wv == 64'h0) check_buf(buf_tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mb[i] = '0; mk[i] = 1'b0; end
    // R1: reset state
    do_reset();
    check("R1 reset idle", link_out, IDLE);
    step(64'h2, 64'h0);
    check("R1 idle after reset", link_out, IDLE);

    // table of scenarios
    for (int s = 0; s < NSC; s++) begin
      do_reset();
      id_valid = 1'b1;
      id_value = {32'hC0DE_0000 | 32'(s), 64'h1357_9BDF_0246_8ACE ^ 64'(s)};
      run_pass(s, 64'hFEDC_BA98_7654_0000 + 64'(s) * 64'h1000,
               SC[s][0], SC[s][1], SC[s][2], SC[s][3], 1'b1,
               (SC[s][1] == 0) ? "R4 no capture" : "R3 capture");
    end

    // R12: write start inside read window
    do_reset();
    id_valid = 1'b1;
    run_pass(10, 64'h0000_0000_0000_5000, 1, 2, 2, 2, 1'b1, "R3 capture");

    // R2: identifier not valid, nothing armed
    do_reset();
    id_valid = 1'b0;
    run_pass(11, 64'h0000_0000_0000_6000, 1, 2, 6, 2, 1'b0, "R2 buffer kept");

    // R11: one pass, then counter revisits the windows
    do_reset();
    id_valid = 1'b1;
    run_pass(12, 64'h0000_0000_0000_7000, 1, 1, 3, 1, 1'b1, "R3 capture");
    run_pass(13, 64'h0000_0000_0000_7000, 1, 1, 3, 1, 1'b0, "R11 buffer kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule